// File: doc/BRIEF.md
# Direct Page Address Generator

This block keeps one 8-bit page register and uses it to widen short direct-mode operands into complete addresses. A register bus port loads the page value and returns it on reads. In normal operating modes only the first write after reset is accepted, and the register then locks. In special operating modes every write is accepted.

On the address side, a request carries a one-byte operand, a direct/non-direct flag, a global/local flag, a full 16-bit address for non-direct accesses and a 7-bit global page. The block returns a 16-bit local address and a 23-bit global address. The request/response path follows valid/ready rules. `rsp_valid` follows `req_valid` in the same cycle, and `req_ready` follows `rsp_ready` in the same cycle. A stalled request must hold its fields stable until the response is accepted. The address outputs are combinational from the request and the registered page value.

Top module: `dp_addr_unit`

## Requirements
- R1: After reset the page register reads 0x00 and the lock is clear.
- R2: A read at register offset 0x11 returns the page value in any mode and lock state. A read at any other offset returns 0x00. A write at any other offset changes nothing.
- R3: When `special_mode` is 1, every write at offset 0x11 sets the page to `reg_wdata` from the next cycle on.
- R4: When `special_mode` is 0, the first write at offset 0x11 after reset is accepted and sets the lock. Later writes in that mode leave the page unchanged.
- R5: The lock stays set until reset. Writes made in special mode while the lock is set are accepted, and after the return to normal mode writes are still refused.
- R6: For a direct access, `rsp_local_addr` = {page, `req_operand`}.
- R7: For a global access, `rsp_global_addr[22:16]` = `req_gpage` and `rsp_global_addr[15:0]` = `rsp_local_addr`. For a local access, bits [22:16] are 0.
- R8: For a non-direct access, `rsp_local_addr` = `req_full_addr`, with no change.
- R9: A write accepted in the same cycle as a request affects only later cycles. That request uses the old page.
- R10: `rsp_valid` equals `req_valid` and `req_ready` equals `rsp_ready` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special operating mode (register always writable) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| req_valid | input | 1 | Address request valid |
| req_ready | output | 1 | Address request ready |
| req_direct | input | 1 | 1 = direct-mode operand |
| req_global | input | 1 | 1 = global access |
| req_operand | input | 8 | Direct operand (low address byte) |
| req_full_addr | input | 16 | Complete address for non-direct accesses |
| req_gpage | input | 7 | Global page bits |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready (back-pressure) |
| rsp_local_addr | output | 16 | Expanded 16-bit address |
| rsp_global_addr | output | 23 | Expanded 23-bit address |

## Verification
Random requests mix the direct and non-direct forms with the global and local forms. This tells the page concatenation apart from the full-address pass-through and from the clearing of the upper bits. Random writes at random offsets, made while `special_mode` toggles, show whether the lock is taken by the first normal-mode write alone and whether it survives a mode change. They also show whether offsets other than 0x11 are ignored. Directed cases put a write and a request in the same cycle to show that the old page is used, and they toggle `rsp_ready` to check that back-pressure passes straight through.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic {
    LK_OPEN = 1'b0,
    LK_SHUT = 1'b1
  } lock_state_t;

  function automatic logic [15:0] dp_join(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/dp_page_reg.sv
module dp_page_reg #(
  parameter int PAGE_W = 8,
  parameter int REG_AW = 8,
  parameter logic [REG_AW-1:0] OFFSET = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] rdata,
  output logic [PAGE_W-1:0] page,
  output logic              locked
);
  import dp_pkg::*;

  lock_state_t lk_q;
  logic [PAGE_W-1:0] page_q;
  logic hit, accept, take_lock;

  always_comb begin
    hit       = wr_en && (addr == OFFSET);
    accept    = hit && (special_mode || (lk_q == LK_OPEN));
    take_lock = hit && !special_mode && (lk_q == LK_OPEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      lk_q   <= LK_OPEN;
    end else begin
      if (accept)    page_q <= wdata;
      if (take_lock) lk_q   <= LK_SHUT;
    end
  end

  assign rdata  = (addr == OFFSET) ? page_q : '0;
  assign page   = page_q;
  assign locked = (lk_q == LK_SHUT);
endmodule

// File: rtl/dp_addr_gen.sv
module dp_addr_gen #(
  parameter int PAGE_W  = 8,
  parameter int GPAGE_W = 7,
  localparam int LADDR_W = 2 * PAGE_W,
  localparam int GADDR_W = LADDR_W + GPAGE_W
) (
  input  logic [PAGE_W-1:0]  page,
  input  logic               direct,
  input  logic               global_acc,
  input  logic [PAGE_W-1:0]  operand,
  input  logic [LADDR_W-1:0] full_addr,
  input  logic [GPAGE_W-1:0] gpage,
  output logic [LADDR_W-1:0] local_addr,
  output logic [GADDR_W-1:0] global_addr
);
  logic [LADDR_W-1:0] low;

  always_comb begin
    low = direct ? {page, operand} : full_addr;
  end

  assign local_addr = low;

  genvar gi;
  generate
    for (gi = 0; gi < GPAGE_W; gi++) begin : g_upper
      assign global_addr[LADDR_W+gi] = global_acc & gpage[gi];
    end
  endgenerate
  assign global_addr[LADDR_W-1:0] = low;
endmodule

// File: rtl/dp_addr_unit.sv
module dp_addr_unit #(
  parameter int PAGE_W  = 8,
  parameter int GPAGE_W = 7,
  parameter int REG_AW  = 8,
  parameter logic [REG_AW-1:0] PAGE_OFFSET = 8'h11,
  localparam int LADDR_W = 2 * PAGE_W,
  localparam int GADDR_W = LADDR_W + GPAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               special_mode,
  input  logic               reg_wr_en,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [PAGE_W-1:0]  reg_wdata,
  output logic [PAGE_W-1:0]  reg_rdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_direct,
  input  logic               req_global,
  input  logic [PAGE_W-1:0]  req_operand,
  input  logic [LADDR_W-1:0] req_full_addr,
  input  logic [GPAGE_W-1:0] req_gpage,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [LADDR_W-1:0] rsp_local_addr,
  output logic [GADDR_W-1:0] rsp_global_addr
);
  logic [PAGE_W-1:0] page_q;
  logic              lock_q;

  dp_page_reg #(.PAGE_W(PAGE_W), .REG_AW(REG_AW), .OFFSET(PAGE_OFFSET)) u_reg (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .page(page_q), .locked(lock_q)
  );

  dp_addr_gen #(.PAGE_W(PAGE_W), .GPAGE_W(GPAGE_W)) u_gen (
    .page(page_q), .direct(req_direct), .global_acc(req_global),
    .operand(req_operand), .full_addr(req_full_addr), .gpage(req_gpage),
    .local_addr(rsp_local_addr), .global_addr(rsp_global_addr)
  );

  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;
endmodule

// File: rtl/dp_addr_unit_chk.sv
module dp_addr_unit_chk #(
  parameter int PAGE_W  = 8,
  parameter int GPAGE_W = 7,
  parameter int REG_AW  = 8,
  parameter logic [REG_AW-1:0] PAGE_OFFSET = 8'h11,
  localparam int LADDR_W = 2 * PAGE_W,
  localparam int GADDR_W = LADDR_W + GPAGE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               special_mode,
  input logic               reg_wr_en,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [PAGE_W-1:0]  reg_wdata,
  input logic               req_direct,
  input logic               req_global,
  input logic               rsp_valid,
  input logic [PAGE_W-1:0]  req_operand,
  input logic [GPAGE_W-1:0] req_gpage,
  input logic [LADDR_W-1:0] rsp_local_addr,
  input logic [GADDR_W-1:0] rsp_global_addr,
  input logic [PAGE_W-1:0]  page,
  input logic               locked
);
  p_special_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (special_mode && reg_wr_en && reg_addr == PAGE_OFFSET) |=> page == $past(reg_wdata));

  p_first_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && !locked && reg_wr_en && reg_addr == PAGE_OFFSET)
      |=> (page == $past(reg_wdata)) && locked);

  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && locked) |=> $stable(page));

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_direct_concat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_direct) |-> rsp_local_addr == {page, req_operand});

  p_global_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_global_addr[GADDR_W-1:LADDR_W] == (req_global ? req_gpage : '0))
                  && (rsp_global_addr[LADDR_W-1:0] == rsp_local_addr));
endmodule

bind dp_addr_unit dp_addr_unit_chk #(
  .PAGE_W(PAGE_W), .GPAGE_W(GPAGE_W), .REG_AW(REG_AW), .PAGE_OFFSET(PAGE_OFFSET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
  .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .req_direct(req_direct), .req_global(req_global), .rsp_valid(rsp_valid),
  .req_operand(req_operand), .req_gpage(req_gpage),
  .rsp_local_addr(rsp_local_addr), .rsp_global_addr(rsp_global_addr),
  .page(page_q), .locked(lock_q)
);

// File: tb/dp_addr_unit_bench.sv
`timescale 1ns/1ps
module dp_addr_unit_bench;
  logic clk = 0, rst_n = 0;
  logic special_mode = 0, reg_wr_en = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic req_valid = 0, req_ready, req_direct = 0, req_global = 0;
  logic [7:0] req_operand = 0;
  logic [15:0] req_full_addr = 0, rsp_local_addr;
  logic [6:0] req_gpage = 0;
  logic rsp_valid, rsp_ready = 0;
  logic [22:0] rsp_global_addr;

  int total = 0, bad = 0;
  logic [7:0] m_page = 0;
  logic m_lock = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dp_addr_unit u_dp_addr_unit (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_local(input logic [7:0] pg, input logic dir,
                                            input logic [7:0] op, input logic [15:0] fa);
    return dir ? {pg, op} : fa;
  endfunction

  function automatic logic [22:0] exp_global(input logic [15:0] lo, input logic gl,
                                             input logic [6:0] gp);
    return {gl ? gp : 7'd0, lo};
  endfunction

  // Apply one cycle: drive after negedge, check combinational outputs, update model at posedge.
  task automatic step(input logic sm, input logic we, input logic [7:0] ad, input logic [7:0] wd,
                      input logic rv, input logic dir, input logic gl, input logic [7:0] op,
                      input logic [15:0] fa, input logic [6:0] gp, input logic rr);
    @(negedge clk);
    special_mode = sm; reg_wr_en = we; reg_addr = ad; reg_wdata = wd;
    req_valid = rv; req_direct = dir; req_global = gl; req_operand = op;
    req_full_addr = fa; req_gpage = gp; rsp_ready = rr;
    #1;
    check(ad == 8'h11 ? "R2 read page" : "R2 read other", reg_rdata, ad == 8'h11 ? m_page : 8'h00);
    check("R10 handshake", {rsp_valid, req_ready}, {rv, rr});
    check(dir ? "R6/R9 local direct" : "R8 local passthru", rsp_local_addr,
          exp_local(m_page, dir, op, fa));
    check("R7 global", rsp_global_addr, exp_global(exp_local(m_page, dir, op, fa), gl, gp));
    @(posedge clk);
    if (we && ad == 8'h11 && (sm || !m_lock)) begin
      m_page = wd;
      if (!sm) m_lock = 1;
    end
  endtask

  initial begin
    #40000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    reg_addr = 8'h11;
    #9;
    check("R1 reset read", reg_rdata, 8'h00);
    @(negedge clk); rst_n = 1;
    // R1: after reset page 0
    step(0, 0, 8'h11, 0, 1, 1, 0, 8'h34, 16'h0, 7'h0, 1);
    // R2: write to wrong offset ignored, lock untaken
    step(0, 1, 8'h12, 8'hAA, 0, 0, 0, 0, 16'h0, 0, 0);
    step(0, 0, 8'h11, 0, 0, 0, 0, 0, 16'h0, 0, 0);
    // R3: special mode writes repeatedly
    step(1, 1, 8'h11, 8'h21, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 8'h11, 8'h42, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 8'h11, 0, 1, 1, 1, 8'h07, 0, 7'h55, 1);
    // R9: write and request same cycle use old page
    step(1, 1, 8'h11, 8'h99, 1, 1, 0, 8'hEE, 0, 0, 1);
    step(1, 0, 8'h11, 0, 1, 1, 0, 8'hEE, 0, 0, 1);
    // R4: first normal write accepted, next refused
    step(0, 1, 8'h11, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 8'h11, 8'h13, 1, 1, 1, 8'h00, 0, 7'h7F, 1);
    step(0, 0, 8'h11, 0, 1, 1, 0, 8'hFF, 0, 0, 0);
    // R5: special write while locked accepted, normal still refused
    step(1, 1, 8'h11, 8'h5A, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 8'h11, 8'hC3, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 8'h11, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R5 lock kept page", reg_rdata, 8'h5A);
    // R8: non-direct passthrough, global and local
    step(0, 0, 8'h11, 0, 1, 0, 1, 8'h12, 16'hBEEF, 7'h3C, 1);
    step(0, 0, 8'h11, 0, 1, 0, 0, 8'h12, 16'hFFFF, 7'h7F, 1);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] ad;
      ad = ($urandom % 4 == 0) ? 8'($urandom) : 8'h11;
      step(1'($urandom), 1'($urandom), ad, 8'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 8'($urandom), 16'($urandom), 7'($urandom), 1'($urandom));
      if (i == 300) begin
        // R1/R4: reset again reopens the lock
        @(negedge clk); rst_n = 0; m_page = 0; m_lock = 0;
        #1; check("R1 reset clears", reg_rdata, 8'h00);
        @(negedge clk); rst_n = 1;
        step(0, 1, 8'h11, 8'h66, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 8'h11, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R4 first write after reset", reg_rdata, 8'h66);
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule